// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a receive path keeps or drops an incoming Ethernet frame. It looks only at the six destination address bytes, which arrive one per qualified cycle after a start strobe. Software-owned settings reach it as plain register inputs: a receive-configuration byte, the 48-bit station address and a 64-bit multicast hash table. Frame storage and body checking belong to other blocks.

While the bytes stream in, the block keeps a running bit-serial CRC over the address. It also tracks whether every byte so far has been all ones, whether the first byte had its group bit set, and whether every byte so far matches the station address. The cycle after the sixth byte is taken, it presents a one-cycle result with the accept decision and the 6-bit hash index.

A three-state machine controls the block. `ST_IDLE` waits for `frame_start` and ignores bytes. `ST_GATHER` takes bytes, moving to `ST_REPORT` on the sixth one. If `frame_start` is seen in any state, the machine goes to `ST_GATHER` and restarts collection, and that takes priority over a byte in the same cycle. `ST_REPORT` lasts exactly one cycle and then returns to `ST_IDLE`, or to `ST_GATHER` if `frame_start` is high in that cycle.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset, `result_valid` and `accept` are low until a full address has been collected.
- R2: `frame_start` reloads the CRC to all ones and discards any bytes already taken, so a frame interrupted mid-address is never reported. The cycle after `frame_start`, `result_valid` is low.
- R3: Bytes count only when `byte_valid` is high in `ST_GATHER`. Bytes seen in idle cycles, and cycles with `byte_valid` low, have no effect. `result_valid` is high for exactly the one cycle after the sixth counted byte, and `accept` is low whenever `result_valid` is low.
- R4: When configuration bit 4 (value 0x10) is set, every frame is accepted.
- R5: A destination of six 0xFF bytes is broadcast. Without configuration bit 4, it is accepted exactly when configuration bit 2 (value 0x04) is set.
- R6: A destination that is not broadcast and whose first byte has bit 0 set is multicast. Without configuration bit 4, it is accepted exactly when configuration bit 3 (value 0x08) is set and `hash_table[hash_index]` is set. That is bit (index mod 8) of table byte (index / 8), where byte k sits in bits 8k+7..8k.
- R7: `hash_index` equals bits 31..26 of a CRC that starts at 0xFFFFFFFF and takes the address bytes in arrival order, least significant bit first. For each bit, feedback = CRC[31] XOR data bit. The CRC is then shifted left one place, and if the feedback is 1 it is XORed with 0x04C11DB6 and bit 0 is set.
- R8: Any other destination is unicast. Without configuration bit 4, it is accepted exactly when all six bytes equal `station_addr`, where the k-th received byte is compared with bits 8k+7..8k. Configuration bits 2 and 3 do not affect this.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Begins a new address, discarding any in progress |
| byte_valid | input | 1 | Qualifies `byte_data` |
| byte_data | input | 8 | Destination address byte, first received byte first |
| rx_cfg | input | 8 | Receive configuration (bit 4 promiscuous, bit 3 multicast, bit 2 broadcast) |
| station_addr | input | 48 | Station address, received byte k in bits 8k+7..8k |
| hash_table | input | 64 | Multicast hash table, bit i for hash index i |
| result_valid | output | 1 | High for one cycle with the decision |
| accept | output | 1 | Frame accepted (qualified by `result_valid`) |
| hash_index | output | 6 | Top six CRC bits of the collected address |

## Verification
The bench sweeps all eight combinations of the promiscuous, multicast and broadcast enables. It runs each combination over broadcast, three multicast addresses (one of them all ones except the last bit), an exact station match and six single-byte mismatches. Each address is tried against a table holding only its own hash bit and against a table holding every bit except that one, which separates a correct index from a wrong one. Varying idle gaps between bytes, stray bytes before the start strobe and a restart in mid-address show whether counting ignores unqualified bytes. The reference CRC is computed in the bench, so an error in the feedback step shows up both as a wrong `hash_index` and as a multicast decision that flips.

// File: rtl/dafilt_pkg.sv
`timescale 1ns/1ps
package dafilt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_REPORT = 2'd2
    } filt_state_e;

    localparam int CFG_PROMISC_BIT = 4;
    localparam int CFG_MCAST_BIT   = 3;
    localparam int CFG_BCAST_BIT   = 2;
endpackage

// File: rtl/dafilt_crc_step.sv
`timescale 1ns/1ps
// One full byte of the bit-serial address CRC, unrolled LSB first.
module dafilt_crc_step #(
    parameter int          CRC_W = 32,
    parameter logic [31:0] POLY  = 32'h04C11DB6
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [7:0]       data_in,
    output logic [CRC_W-1:0] crc_out
);
    logic [CRC_W-1:0] stage [0:8];

    assign stage[0] = crc_in;

    for (genvar b = 0; b < 8; b++) begin : g_bit
        logic             fb;
        logic [CRC_W-1:0] shifted;
        assign fb      = stage[b][CRC_W-1] ^ data_in[b];
        assign shifted = {stage[b][CRC_W-2:0], 1'b0};
        assign stage[b+1] = fb ? ((shifted ^ POLY[CRC_W-1:0]) | {{(CRC_W-1){1'b0}}, 1'b1})
                               : shifted;
    end

    assign crc_out = stage[8];
endmodule

// File: rtl/dafilt_addr_track.sv
`timescale 1ns/1ps
// Running per-byte classification flags for the destination address.
module dafilt_addr_track #(
    parameter int N_BYTES = 6,
    parameter int IDX_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 load,
    input  logic [IDX_W-1:0]     byte_idx,
    input  logic [7:0]           byte_data,
    input  logic [8*N_BYTES-1:0] station_addr,
    output logic                 all_ones,
    output logic                 group_bit,
    output logic                 station_hit
);
    logic [7:0] expect_byte;

    always_comb begin
        expect_byte = station_addr[int'(byte_idx)*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            all_ones    <= 1'b1;
            group_bit   <= 1'b0;
            station_hit <= 1'b1;
        end else if (clear) begin
            all_ones    <= 1'b1;
            group_bit   <= 1'b0;
            station_hit <= 1'b1;
        end else if (load) begin
            all_ones    <= all_ones & (byte_data == 8'hFF);
            station_hit <= station_hit & (byte_data == expect_byte);
            if (byte_idx == '0) begin
                group_bit <= byte_data[0];
            end
        end
    end
endmodule

// File: rtl/dafilt_decide.sv
`timescale 1ns/1ps
// Combinational accept decision in priority order.
module dafilt_decide #(
    parameter int HASH_W = 6
) (
    input  logic                 promisc_en,
    input  logic                 mcast_en,
    input  logic                 bcast_en,
    input  logic                 all_ones,
    input  logic                 group_bit,
    input  logic                 station_hit,
    input  logic [2**HASH_W-1:0] hash_table,
    input  logic [HASH_W-1:0]    hash_index,
    output logic                 keep
);
    always_comb begin
        if (promisc_en) begin
            keep = 1'b1;
        end else if (all_ones) begin
            keep = bcast_en;
        end else if (group_bit) begin
            keep = mcast_en & hash_table[hash_index];
        end else begin
            keep = station_hit;
        end
    end
endmodule

// File: rtl/dest_addr_filter.sv
`timescale 1ns/1ps
module dest_addr_filter
    import dafilt_pkg::*;
#(
    parameter int          N_BYTES = 6,
    parameter int          CRC_W   = 32,
    parameter int          HASH_W  = 6,
    parameter logic [31:0] POLY    = 32'h04C11DB6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic                 byte_valid,
    input  logic [7:0]           byte_data,
    input  logic [7:0]           rx_cfg,
    input  logic [8*N_BYTES-1:0] station_addr,
    input  logic [2**HASH_W-1:0] hash_table,
    output logic                 result_valid,
    output logic                 accept,
    output logic [HASH_W-1:0]    hash_index
);
    localparam int               IDX_W    = (N_BYTES > 1) ? $clog2(N_BYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_BYTES - 1);

    filt_state_e      state_q, state_d;
    logic [IDX_W-1:0] cnt_q;
    logic [CRC_W-1:0] crc_q, crc_next;
    logic             take_byte;
    logic             all_ones, group_bit, station_hit, keep;
    logic             unused_cfg;

    assign unused_cfg = ^{rx_cfg[7:5], rx_cfg[1:0]};
    assign take_byte  = (state_q == ST_GATHER) && byte_valid && !frame_start;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (frame_start) state_d = ST_GATHER;
            ST_GATHER: begin
                if (frame_start)                          state_d = ST_GATHER;
                else if (byte_valid && cnt_q == LAST_IDX) state_d = ST_REPORT;
            end
            ST_REPORT: state_d = frame_start ? ST_GATHER : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Byte counter and CRC accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            crc_q <= '1;
        end else if (frame_start) begin
            cnt_q <= '0;
            crc_q <= '1;
        end else if (take_byte) begin
            cnt_q <= (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
            crc_q <= crc_next;
        end
    end

    dafilt_crc_step #(.CRC_W(CRC_W), .POLY(POLY)) u_crc (
        .crc_in  (crc_q),
        .data_in (byte_data),
        .crc_out (crc_next)
    );

    dafilt_addr_track #(.N_BYTES(N_BYTES), .IDX_W(IDX_W)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (frame_start),
        .load         (take_byte),
        .byte_idx     (cnt_q),
        .byte_data    (byte_data),
        .station_addr (station_addr),
        .all_ones     (all_ones),
        .group_bit    (group_bit),
        .station_hit  (station_hit)
    );

    dafilt_decide #(.HASH_W(HASH_W)) u_decide (
        .promisc_en  (rx_cfg[CFG_PROMISC_BIT]),
        .mcast_en    (rx_cfg[CFG_MCAST_BIT]),
        .bcast_en    (rx_cfg[CFG_BCAST_BIT]),
        .all_ones    (all_ones),
        .group_bit   (group_bit),
        .station_hit (station_hit),
        .hash_table  (hash_table),
        .hash_index  (hash_index),
        .keep        (keep)
    );

    // Output logic
    always_comb begin
        hash_index   = crc_q[CRC_W-1 -: HASH_W];
        result_valid = (state_q == ST_REPORT);
        accept       = result_valid & keep;
    end
endmodule

// File: rtl/dest_addr_filter_chk.sv
`timescale 1ns/1ps
module dest_addr_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_start,
    input logic       byte_valid,
    input logic [7:0] rx_cfg,
    input logic       result_valid,
    input logic       accept
);
    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R3
    follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $past(byte_valid));

    // R3
    qualified_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> !accept);

    // R2
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !result_valid);

    // R4
    promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && rx_cfg[4]) |-> accept);
endmodule

bind dest_addr_filter dest_addr_filter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .byte_valid   (byte_valid),
    .rx_cfg       (rx_cfg),
    .result_valid (result_valid),
    .accept       (accept)
);

// File: tb/dest_addr_filter_test.sv
`timescale 1ns/1ps
module dest_addr_filter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic [7:0]  rx_cfg = 8'h00;
    logic [47:0] station_addr = 48'h5E4D3C2B1A52;
    logic [63:0] hash_table = 64'h0;
    logic        result_valid, accept;
    logic [5:0]  hash_index;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    dest_addr_filter uut (
        .clk, .rst_n, .frame_start, .byte_valid, .byte_data, .rx_cfg,
        .station_addr, .hash_table, .result_valid, .accept, .hash_index
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [47:0] a);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic fb = c[31] ^ a[8*i+j];
                c = c << 1;
                if (fb) c = (c ^ 32'h04C11DB6) | 32'h1;
            end
        end
        return c;
    endfunction

    function automatic bit ref_accept(input logic [7:0] cfg, input logic [47:0] a,
                                      input logic [63:0] tbl, input logic [47:0] st);
        logic [5:0] idx = ref_crc(a)[31:26];
        if (cfg[4]) return 1'b1;
        if (a == 48'hFFFFFFFFFFFF) return cfg[2];
        if (a[0]) return cfg[3] & tbl[idx];
        return a == st;
    endfunction

    // Drives one address; optional stray byte before start and idle gaps.
    task automatic run_frame(input logic [47:0] a, input int gaps);
        if (gaps > 0) begin
            @(negedge clk); byte_valid = 1'b1; byte_data = 8'hA5;
        end
        @(negedge clk); byte_valid = 1'b0; frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        for (int k = 0; k < 6; k++) begin
            for (int g = 0; g < gaps; g++) begin
                byte_valid = 1'b0; byte_data = 8'hFF;
                @(negedge clk);
            end
            byte_valid = 1'b1; byte_data = a[8*k +: 8];
            if (k < 5) begin
                @(negedge clk);
                check(result_valid == 1'b0, "R3 early valid", result_valid, 0);
            end
        end
        @(negedge clk); byte_valid = 1'b0;
    endtask

    initial begin
        logic [47:0] addrs [0:9];
        addrs[0] = 48'hFFFFFFFFFFFF;
        addrs[1] = 48'h302010_5E0001;
        addrs[2] = 48'h010000_003333;
        addrs[3] = 48'hFEFFFFFFFFFF;
        addrs[4] = station_addr;
        for (int k = 0; k < 5; k++) addrs[5+k] = station_addr ^ (48'h2 << (8*k));

        repeat (3) @(negedge clk);
        // R1
        check(result_valid == 1'b0, "R1 valid at reset", result_valid, 0);
        check(accept == 1'b0, "R1 accept at reset", accept, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(result_valid == 1'b0, "R1 valid after reset", result_valid, 0);

        for (int cls = 0; cls < 11; cls++) begin
            for (int t = 0; t < 2; t++) begin
                for (int c = 0; c < 8; c++) begin
                    logic [47:0] a;
                    logic [5:0]  idx;
                    bit          exp;
                    a = (cls == 10) ? (station_addr ^ (48'h2 << 40)) : addrs[cls];
                    idx = ref_crc(a)[31:26];
                    hash_table = t ? ~(64'h1 << idx) : (64'h1 << idx);
                    rx_cfg = {3'b000, c[2], c[1], c[0], 2'b00};
                    exp = ref_accept(rx_cfg, a, hash_table, station_addr);
                    run_frame(a, c % 3);
                    check(result_valid == 1'b1, "R3 valid after sixth byte", result_valid, 1);
                    check(hash_index == idx, "R7 hash index", hash_index, idx);
                    if (c[2])
                        check(accept == 1'b1, "R4 promiscuous", accept, 1);
                    else if (cls == 0)
                        check(accept == exp, "R5 broadcast", accept, exp);
                    else if (cls <= 3)
                        check(accept == exp, "R6 multicast hash", accept, exp);
                    else
                        check(accept == exp, "R8 unicast match", accept, exp);
                    @(negedge clk);
                    check(result_valid == 1'b0, "R3 single cycle", result_valid, 0);
                    check(accept == 1'b0, "R3 accept qualified", accept, 0);
                end
            end
        end

        // R2: restart in mid-address, junk bytes discarded
        rx_cfg = 8'h00;
        hash_table = 64'h0;
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            byte_valid = 1'b1; byte_data = 8'h77;
            @(negedge clk);
        end
        byte_valid = 1'b0;
        run_frame(station_addr, 0);
        check(result_valid == 1'b1, "R2 restart valid", result_valid, 1);
        check(accept == 1'b1, "R2 restart accept", accept, 1);
        check(hash_index == ref_crc(station_addr)[31:26], "R2 restart crc reload",
              hash_index, ref_crc(station_addr)[31:26]);

        // R3: bytes while idle produce nothing
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); byte_valid = 1'b1; byte_data = station_addr[8*(k%6) +: 8];
            check(result_valid == 1'b0, "R3 idle bytes ignored", result_valid, 0);
        end
        byte_valid = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule